// File: doc/BRIEF.md
# Local Bus Target Handshake Controller

This block is the target side of a parallel local bus driven by a bridge device. The bridge asks for the bus with a hold request. The controller grants it with a hold acknowledge, then waits for an active-low address strobe. The direction input picks a write or a read. A write is accepted one beat per cycle with an active-low ready, and each beat is handed to an internal register port. A read returns one word from that register port on the shared data bus. The read word is driven only while the output enable is high, and the ready is low for that single cycle.

After a data phase the controller enters a completion state. If the bridge drops its hold request there, the controller goes back to idle. If the bridge keeps the hold request and flags the last beat, the controller goes back to the held state for another access. The register port is a small bank of word-wide registers, indexed by the latched address. Its write strobe, address and data are also brought out so that nearby logic can watch writes.

Top module: `lbus_target`

## Requirements
- R1: While reset is asserted and right after it, hold_ack_o is 0, ready_n_o is 1, data_oe_o is 0, wr_stb_o is 0, and every register reads back as 0.
- R2: In idle, a sampled hold_req_i of 1 moves the controller to the held state, and hold_ack_o is 1 from the next cycle on. With hold_req_i at 0 the controller stays idle whatever the other inputs do, and it makes no write.
- R3: In the held state, ads_n_i at 0 with wr_rd_i at 1 (1 means write) leads to the write state on the next cycle. ads_n_i at 1 keeps the held state. hold_req_i at 0 returns the controller to idle, and this takes priority over the strobe.
- R4: In the write state, ready_n_o is 0 and wr_stb_o is 1 every cycle. wr_data_o is the current data_i. The state is kept while blast_n_i is 1 and left for completion after a cycle in which blast_n_i (active low, 0 marks the last beat) is sampled 0.
- R5: In the held state, ads_n_i at 0 with wr_rd_i at 0 leads to a read state that lasts exactly one cycle. In that cycle ready_n_o is 0, data_oe_o is 1, and data_o is the addressed register. The controller then enters completion.
- R6: The address is captured from addr_i in the cycle that ads_n_i is sampled 0 in the held state. Later changes on addr_i do not change wr_addr_o or the register that is read or written.
- R7: In completion, hold_req_i at 0 returns the controller to idle, so hold_ack_o is 0 on the next cycle. hold_req_i at 1 with blast_n_i at 0 returns it to the held state. Any other input keeps it in completion. ready_n_o is 1 there.
- R8: hold_ack_o stays 1 in the held, write, read and completion states, and it is 0 only in idle.
- R9: data_oe_o is 1 only in the read state, and data_o is 0 whenever data_oe_o is 0.
- R10: There are NREG registers at addresses 0 to NREG-1. A write to a higher address is ignored, and a read from a higher address returns 0. Each register keeps its value until it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion is synchronized inside |
| hold_req_i | input | 1 | Bus request from the bridge |
| hold_ack_o | output | 1 | Bus grant to the bridge |
| addr_i | input | ADDR_W | Address bus |
| ads_n_i | input | 1 | Address strobe, active low |
| wr_rd_i | input | 1 | Direction, 1 = write, 0 = read |
| blast_n_i | input | 1 | Last-beat flag, active low |
| data_i | input | DATA_W | Write data from the bridge |
| data_o | output | DATA_W | Read data toward the bridge |
| data_oe_o | output | 1 | Output enable for data_o |
| ready_n_o | output | 1 | Beat ready, active low |
| wr_stb_o | output | 1 | Register port write strobe |
| wr_addr_o | output | ADDR_W | Register port latched address |
| wr_data_o | output | DATA_W | Register port write data |

## Verification
The assertions assume the bridge follows the protocol. It raises the address strobe only while it holds the bus. It keeps hold_req_i steady through a data phase. It flags the last beat with blast_n_i before it releases the bus. Each bench task starts a transfer from idle, drives inputs half a cycle away from the sampling edge, and ends the transfer through completion. The only deliberate departures are hold drops in the held and completion states and strobe activity while idle. Both are legal cases that the requirements define.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HELD  = 3'd1,
    ST_WRITE = 3'd2,
    ST_READ  = 3'd3,
    ST_DONE  = 3'd4
  } lbus_state_e;

endpackage

// File: rtl/lbus_rst_sync.sv
module lbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/lbus_fsm.sv
module lbus_fsm
  import lbus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hold_req_i,
  input  logic        ads_n_i,
  input  logic        wr_rd_i,
  input  logic        blast_n_i,
  output lbus_state_e state_o,
  output logic        addr_cap_o
);

  lbus_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hold_req_i) state_d = ST_HELD;
      end
      ST_HELD: begin
        if (!hold_req_i)   state_d = ST_IDLE;
        else if (!ads_n_i) state_d = wr_rd_i ? ST_WRITE : ST_READ;
      end
      ST_WRITE: begin
        if (!blast_n_i) state_d = ST_DONE;
      end
      ST_READ: begin
        state_d = ST_DONE;
      end
      ST_DONE: begin
        if (!hold_req_i)      state_d = ST_IDLE;
        else if (!blast_n_i)  state_d = ST_HELD;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state_o    = state_q;
  assign addr_cap_o = (state_q == ST_HELD) && hold_req_i && !ads_n_i;

  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && hold_req_i) |=> (state_q == ST_HELD));

  // R3
  held_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HELD && !hold_req_i) |=> (state_q == ST_IDLE));

  // R4
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && blast_n_i) |=> (state_q == ST_WRITE));

  // R5
  read_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ) |=> (state_q == ST_DONE));

  // R7
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && !hold_req_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/lbus_addr_reg.sv
module lbus_addr_reg #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] d_i,
  output logic [ADDR_W-1:0] q_o
);

  logic [ADDR_W-1:0] q_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (en_i) q_q <= d_i;
  end

  assign q_o = q_q;

endmodule

// File: rtl/lbus_regfile.sv
module lbus_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(NREG - 1);

  logic [NREG-1:0][DATA_W-1:0] regs_q;
  logic [NREG-1:0]             hit;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign hit[i] = (addr_i == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                regs_q[i] <= '0;
      else if (we_i && hit[i])   regs_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rdata_o = regs_q[i];
    end
  end

  // R10
  oor_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i > LAST_IDX) |=> $stable(regs_q));

endmodule

// File: rtl/lbus_target.sv
module lbus_target
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_req_i,
  output logic              hold_ack_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_n_i,
  input  logic              wr_rd_i,
  input  logic              blast_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ready_n_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic              rst_sync_n;
  lbus_state_e       state;
  logic              addr_cap;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rdata;

  lbus_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lbus_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .hold_req_i (hold_req_i),
    .ads_n_i    (ads_n_i),
    .wr_rd_i    (wr_rd_i),
    .blast_n_i  (blast_n_i),
    .state_o    (state),
    .addr_cap_o (addr_cap)
  );

  lbus_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_i  (addr_cap),
    .d_i   (addr_i),
    .q_o   (addr_q)
  );

  lbus_regfile #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NREG   (NREG)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (wr_stb_o),
    .addr_i  (addr_q),
    .wdata_i (data_i),
    .rdata_o (rdata)
  );

  // Moore decode of the bus-side outputs
  assign hold_ack_o = (state != ST_IDLE);
  assign ready_n_o  = !((state == ST_WRITE) || (state == ST_READ));
  assign data_oe_o  = (state == ST_READ);
  assign data_o     = data_oe_o ? rdata : '0;
  assign wr_stb_o   = (state == ST_WRITE);
  assign wr_addr_o  = addr_q;
  assign wr_data_o  = data_i;

  // R8
  ready_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ready_n_o |-> hold_ack_o);

  // R5
  oe_single_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_oe_o |=> !data_oe_o);

  // R6
  wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb_o && $past(wr_stb_o)) |-> $stable(wr_addr_o));

  // R9
  data_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !data_oe_o |-> (data_o == '0));

endmodule

// File: tb/lbus_target_tb.sv
module lbus_target_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NR = 4;

  logic          clk;
  logic          rst_n;
  logic          hold_req;
  logic          hold_ack;
  logic [AW-1:0] addr;
  logic          ads_n;
  logic          wr_rd;
  logic          blast_n;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          oe;
  logic          ready_n;
  logic          wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int tests;
  int fails;
  logic [DW-1:0] mdl [NR];

  lbus_target #(.ADDR_W(AW), .DATA_W(DW), .NREG(NR)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_req_i (hold_req),
    .hold_ack_o (hold_ack),
    .addr_i     (addr),
    .ads_n_i    (ads_n),
    .wr_rd_i    (wr_rd),
    .blast_n_i  (blast_n),
    .data_i     (din),
    .data_o     (dout),
    .data_oe_o  (oe),
    .ready_n_o  (ready_n),
    .wr_stb_o   (wr_stb),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
    return (int'(a) < NR) ? mdl[int'(a)] : '0;
  endfunction

  task automatic idle_bus();
    hold_req = 1'b0; ads_n = 1'b1; wr_rd = 1'b0; blast_n = 1'b1;
  endtask

  // starts and ends in idle; beats >= 1
  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int beats);
    @(negedge clk); hold_req = 1'b1;
    @(negedge clk); #1;
    chk("R2 grant", {31'd0, hold_ack}, 32'd1);
    ads_n = 1'b0; wr_rd = 1'b1; addr = a;
    for (int b = 0; b < beats; b++) begin
      @(negedge clk);
      ads_n = 1'b1; addr = ~a; din = d + DW'(b);
      blast_n = (b == beats - 1) ? 1'b0 : 1'b1;
      #1;
      chk("R4 ready_n", {31'd0, ready_n}, 32'd0);
      chk("R4 wr_stb", {31'd0, wr_stb}, 32'd1);
      chk("R4 wr_data", {16'd0, wr_data}, {16'd0, d + DW'(b)});
      chk("R6 wr_addr", {28'd0, wr_addr}, {28'd0, a});
      chk("R9 oe in write", {31'd0, oe}, 32'd0);
    end
    @(negedge clk); blast_n = 1'b1; hold_req = 1'b0; #1;
    chk("R8 ack in done", {31'd0, hold_ack}, 32'd1);
    chk("R7 ready_n in done", {31'd0, ready_n}, 32'd1);
    chk("R4 left write", {31'd0, wr_stb}, 32'd0);
    @(negedge clk); #1;
    chk("R7 release", {31'd0, hold_ack}, 32'd0);
    if (int'(a) < NR) mdl[int'(a)] = d + DW'(beats - 1);
  endtask

  task automatic bus_read(input logic [AW-1:0] a);
    @(negedge clk); hold_req = 1'b1;
    @(negedge clk); ads_n = 1'b0; wr_rd = 1'b0; addr = a;
    @(negedge clk); ads_n = 1'b1; addr = ~a; blast_n = 1'b0; #1;
    chk("R5 oe", {31'd0, oe}, 32'd1);
    chk("R5 ready_n", {31'd0, ready_n}, 32'd0);
    chk("R10 R6 read data", {16'd0, dout}, {16'd0, expect_rd(a)});
    @(negedge clk); blast_n = 1'b1; hold_req = 1'b0; #1;
    chk("R9 oe after read", {31'd0, oe}, 32'd0);
    chk("R9 data quiet", {16'd0, dout}, 32'd0);
    chk("R8 ack after read", {31'd0, hold_ack}, 32'd1);
    @(negedge clk); #1;
    chk("R7 idle after read", {31'd0, hold_ack}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0;
    for (int i = 0; i < NR; i++) mdl[i] = '0;
    idle_bus(); addr = '0; din = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1 ack", {31'd0, hold_ack}, 32'd0);
    chk("R1 ready_n", {31'd0, ready_n}, 32'd1);
    chk("R1 oe", {31'd0, oe}, 32'd0);
    chk("R1 wr_stb", {31'd0, wr_stb}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 registers zero after reset
    for (int a = 0; a < NR; a++) bus_read(AW'(a));

    // R2 stays idle without request, strobes ignored
    @(negedge clk); ads_n = 1'b0; wr_rd = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R2 idle ack", {31'd0, hold_ack}, 32'd0);
      chk("R2 idle no write", {31'd0, wr_stb}, 32'd0);
    end
    idle_bus();

    // R3 held without strobe, then hold drop returns idle
    @(negedge clk); hold_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R3 held ack", {31'd0, hold_ack}, 32'd1);
      chk("R3 held ready_n", {31'd0, ready_n}, 32'd1);
    end
    hold_req = 1'b0; ads_n = 1'b0; wr_rd = 1'b1;
    @(negedge clk); #1;
    chk("R3 drop wins", {31'd0, hold_ack}, 32'd0);
    @(negedge clk); #1;
    chk("R3 no write after drop", {31'd0, wr_stb}, 32'd0);
    idle_bus();

    // exhaustive address sweep with varying burst lengths
    for (int a = 0; a < (1 << AW); a++)
      bus_write(AW'(a), DW'(a * 16'h1111) ^ 16'hA5C3, 1 + (a % 3));
    for (int a = 0; a < (1 << AW); a++) bus_read(AW'(a));

    // R7 completion stays, then re-arms to held, then read from there
    @(negedge clk); hold_req = 1'b1;
    @(negedge clk); ads_n = 1'b0; wr_rd = 1'b1; addr = 4'd2;
    @(negedge clk); ads_n = 1'b1; din = 16'h5A5A; blast_n = 1'b0;
    @(negedge clk); blast_n = 1'b1; #1;
    chk("R7 in done", {31'd0, ready_n}, 32'd1);
    @(negedge clk); #1;
    chk("R7 done stays ack", {31'd0, hold_ack}, 32'd1);
    chk("R7 done stays ready_n", {31'd0, ready_n}, 32'd1);
    chk("R7 done no write", {31'd0, wr_stb}, 32'd0);
    mdl[2] = 16'h5A5A;
    blast_n = 1'b0;
    @(negedge clk); blast_n = 1'b1; ads_n = 1'b0; wr_rd = 1'b0; addr = 4'd2; #1;
    chk("R7 rearm held ack", {31'd0, hold_ack}, 32'd1);
    chk("R7 rearm held ready_n", {31'd0, ready_n}, 32'd1);
    @(negedge clk); ads_n = 1'b1; #1;
    chk("R7 R5 rearm read", {16'd0, dout}, {16'd0, mdl[2]});
    @(negedge clk); hold_req = 1'b0;
    @(negedge clk); #1;
    chk("R7 final idle", {31'd0, hold_ack}, 32'd0);
    idle_bus();

    for (int a = 0; a < NR; a++) bus_read(AW'(a));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule